// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Not-Most-Recently-Used Replacement

This block is a read/write cache for a 32-bit byte-addressed processor port. It has two ways and 512 sets, and each line holds 32 bytes. On each accepted request, the block reads the tags, valid bits and lines of both ways of the indexed set in the same cycle. A hit returns the selected 32-bit word one cycle after acceptance. On a miss, the block stalls the processor port, asks a line-fill port for the aligned line and waits for the line to come back. It then writes the line into the chosen way and returns the requested word.

Each set keeps a single bit that names its most recently used way. Every hit and every fill rewrites this bit. A miss always replaces the other way, so with two ways this policy is exact least-recently-used. A write that hits changes only the addressed word of the cached line. A write that misses first fills the line and then merges the written word into it. Writing data back to memory is not part of this block.

Top module: `c2w_cache`

## Requirements
- R1: Address bits [4:2] select the 32-bit word within a line, bits [13:5] select one of 512 sets, and bits [31:14] are the tag. Addresses that differ only in bits [4:0] share one line.
- R2: An accepted request whose set holds a valid way with a matching tag produces `rsp_valid` in the next cycle, with `rsp_hit`=1 and the selected word on `rsp_rdata`.
- R3: An accepted request that misses raises `mem_req_valid` with `mem_req_addr` equal to the request address with bits [4:0] cleared. Both stay unchanged until `mem_req_ready` is sampled high.
- R4: When `mem_fill_valid` is sampled high while a fill is outstanding, the line is written into the victim way and marked valid. In the next cycle `rsp_valid`=1 and `rsp_hit`=0, and `rsp_rdata` carries the requested word, so the word is forwarded in the same cycle in which the line is written.
- R5: On a miss, the victim is the way that the set's MRU bit does not name. After reset every MRU bit is 0, so the first fill of a set goes to way 1.
- R6: Every hit and every fill sets the set's MRU bit to the accessed way. In the access order A, B, A, C to one set, C therefore evicts B and A stays resident.
- R7: `req_ready` is low from the cycle after a miss is accepted until the fill response cycle. Requests presented in that window are not taken.
- R8: Reset clears every valid bit, so the first access to any address after reset misses. During reset `req_ready`=1, and `rsp_valid` and `mem_req_valid` are 0.
- R9: A write hit (`req_write`=1) replaces only the addressed word of the line. It responds with `rsp_hit`=1 and the written value on `rsp_rdata`.
- R10: A write miss fills the line, merges the written word into it and responds with `rsp_hit`=0 and the written value. Later reads of that word return the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write a word, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Word to write |
| req_ready | output | 1 | Request taken on a clock edge where req_valid and req_ready are both high |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | 1 = response served from a resident line |
| rsp_rdata | output | 32 | Read word, or the written word for writes |
| mem_req_valid | output | 1 | Line fill requested |
| mem_req_addr | output | 32 | Line-aligned address of the fill |
| mem_req_ready | input | 1 | Memory takes the fill request |
| mem_fill_valid | input | 1 | Fill line present |
| mem_fill_data | input | 256 | Fill line, word 0 in bits [31:0] |

## Verification
A fill edge does three things at once: it writes the line, rewrites the set's MRU bit and forwards the requested word to the processor. On a write miss, the merge of the written word also falls on that edge. The bench provokes these cases with conflicting addresses in one set and with a write miss. A scoreboard with its own model of tags, valid bits and MRU bits judges the forwarded word and hit flag. Follow-up accesses then show whether the line, the merged word and the MRU bit each landed correctly, because a wrong one turns a later expected hit into a miss or returns a stale word.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 5;
    localparam int IDX_W  = 9;
    localparam int WORD_W = 32;
    localparam int WAYS   = 2;
    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = 8 * (1 << OFF_W);
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = $clog2(WORD_W / 8);

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [BSEL_W-1:0] bsel;
    } c2w_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } c2w_state_e;

    function automatic word_t get_word(line_t l, logic [WSEL_W-1:0] s);
        return l[int'(s)*WORD_W +: WORD_W];
    endfunction

    function automatic line_t put_word(line_t l, logic [WSEL_W-1:0] s, word_t w);
        line_t r;
        r = l;
        r[int'(s)*WORD_W +: WORD_W] = w;
        return r;
    endfunction
endpackage

// File: rtl/c2w_tag_store.sv
module c2w_tag_store
    import c2w_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]     rd_tags,
    output logic [WAYS-1:0]                rd_valid,
    output logic                           rd_mru,
    input  logic                           fill_en,
    input  logic [TAG_W-1:0]               fill_tag,
    input  logic                           upd_en,
    input  logic                           upd_way,
    input  logic [IDX_W-1:0]               upd_idx
);
    logic [TAG_W-1:0] tags [WAYS][SETS];
    logic [SETS-1:0]  valid_q [WAYS];
    logic [SETS-1:0]  mru_q;

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags[upd_way][upd_idx] <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                valid_q[w] <= '0;
            end
            mru_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[upd_way][upd_idx] <= 1'b1;
            end
            if (upd_en) begin
                mru_q[upd_idx] <= upd_way;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w]  = tags[w][rd_idx];
        assign rd_valid[w] = valid_q[w][rd_idx];
    end
    assign rd_mru = mru_q[rd_idx];
endmodule

// File: rtl/c2w_data_store.sv
module c2w_data_store
    import c2w_pkg::*;
(
    input  logic                        clk,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][LINE_W-1:0] rd_lines,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic [IDX_W-1:0]            wr_idx,
    input  line_t                       wr_line
);
    line_t lines [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines[wr_way][wr_idx] <= wr_line;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_lines[w] = lines[w][rd_idx];
    end
endmodule

// File: rtl/c2w_way_match.sv
module c2w_way_match
    import c2w_pkg::*;
(
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic                       hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == look_tag);
    end

    assign hit     = |match;
    assign hit_way = match[1];
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
    import c2w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  word_t              req_wdata,
    output logic               req_ready,
    output logic [IDX_W-1:0]   look_idx,
    output logic [TAG_W-1:0]   look_tag,
    input  logic               hit,
    input  logic               hit_way,
    input  line_t              hit_line,
    input  logic               set_mru,
    output logic               fill_en,
    output logic [TAG_W-1:0]   fill_tag,
    output logic               upd_en,
    output logic               upd_way,
    output logic               data_we,
    output line_t              data_line,
    input  logic               mem_req_ready,
    input  logic               mem_fill_valid,
    input  line_t              mem_fill_data,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output word_t              rsp_rdata
);
    c2w_state_e st_q, st_d;
    c2w_addr_t  cur, pend_q;
    logic       pend_wr_q;
    word_t      pend_wd_q;
    logic       accept, hit_acc, miss_acc, fill, victim;
    line_t      fill_line;

    assign cur       = c2w_addr_t'(req_addr);
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign hit_acc   = accept && hit;
    assign miss_acc  = accept && !hit;
    assign fill      = (st_q == ST_WAIT) && mem_fill_valid;
    assign victim    = ~set_mru;

    assign look_idx  = req_ready ? cur.idx : pend_q.idx;
    assign look_tag  = cur.tag;

    assign fill_line = pend_wr_q ? put_word(mem_fill_data, pend_q.wsel, pend_wd_q)
                                 : mem_fill_data;

    assign fill_en   = fill;
    assign fill_tag  = pend_q.tag;
    assign upd_en    = hit_acc || fill;
    assign upd_way   = fill ? victim : hit_way;
    assign data_we   = fill || (hit_acc && req_write);
    assign data_line = fill ? fill_line : put_word(hit_line, cur.wsel, req_wdata);

    assign mem_req_valid = (st_q == ST_REQ);
    assign mem_req_addr  = {pend_q.tag, pend_q.idx, {OFF_W{1'b0}}};

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (miss_acc)       st_d = ST_REQ;
            ST_REQ:  if (mem_req_ready)  st_d = ST_WAIT;
            ST_WAIT: if (mem_fill_valid) st_d = ST_IDLE;
            default:                     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pend_q    <= '0;
            pend_wr_q <= 1'b0;
            pend_wd_q <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            st_q      <= st_d;
            rsp_valid <= hit_acc || fill;
            rsp_hit   <= hit_acc;
            if (miss_acc) begin
                pend_q    <= cur;
                pend_wr_q <= req_write;
                pend_wd_q <= req_wdata;
            end
            if (hit_acc) begin
                rsp_rdata <= req_write ? req_wdata : get_word(hit_line, cur.wsel);
            end else if (fill) begin
                rsp_rdata <= pend_wr_q ? pend_wd_q : get_word(mem_fill_data, pend_q.wsel);
            end
        end
    end
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache
    import c2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_rdata,
    output logic              mem_req_valid,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_fill_valid,
    input  logic [255:0]      mem_fill_data
);
    logic [IDX_W-1:0]            look_idx;
    logic [TAG_W-1:0]            look_tag;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][LINE_W-1:0] rd_lines;
    logic                        set_mru;
    logic                        hit, hit_way;
    logic                        fill_en, upd_en, upd_way, data_we;
    logic [TAG_W-1:0]            fill_tag;
    line_t                       data_line, hit_line;

    assign hit_line = rd_lines[hit_way];

    c2w_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_tags  (rd_tags),
        .rd_valid (rd_valid),
        .rd_mru   (set_mru),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .upd_en   (upd_en),
        .upd_way  (upd_way),
        .upd_idx  (look_idx)
    );

    c2w_data_store u_data (
        .clk      (clk),
        .rd_idx   (look_idx),
        .rd_lines (rd_lines),
        .wr_en    (data_we),
        .wr_way   (upd_way),
        .wr_idx   (look_idx),
        .wr_line  (data_line)
    );

    c2w_way_match u_match (
        .tags     (rd_tags),
        .valid    (rd_valid),
        .look_tag (look_tag),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    c2w_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_ready      (req_ready),
        .look_idx       (look_idx),
        .look_tag       (look_tag),
        .hit            (hit),
        .hit_way        (hit_way),
        .hit_line       (hit_line),
        .set_mru        (set_mru),
        .fill_en        (fill_en),
        .fill_tag       (fill_tag),
        .upd_en         (upd_en),
        .upd_way        (upd_way),
        .data_we        (data_we),
        .data_line      (data_line),
        .mem_req_ready  (mem_req_ready),
        .mem_fill_valid (mem_fill_valid),
        .mem_fill_data  (mem_fill_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_rdata      (rsp_rdata)
    );
endmodule

// File: rtl/c2w_chk.sv
module c2w_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_fill_valid,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        fill_we,
    input logic        fill_way,
    input logic        mru_now
);
    AST_STALL_WHILE_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[4:0] == 5'd0)); // R3

    AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid || mem_req_valid)); // R2

    AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (mem_fill_valid && !req_ready && !mem_req_valid) |=> (rsp_valid && !rsp_hit)); // R4

    AST_READY_AT_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready); // R7

    AST_VICTIM_NOT_MRU: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> (fill_way != mru_now)); // R5
endmodule

bind c2w_cache c2w_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_fill_valid (mem_fill_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .fill_we        (fill_en),
    .fill_way       (upd_way),
    .mru_now        (set_mru)
);

// File: tb/test_c2w_cache.sv
`timescale 1ns/100ps
module test_c2w_cache;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         req_ready, rsp_valid, rsp_hit, mem_req_valid;
    logic [31:0]  rsp_rdata, mem_req_addr;
    logic         mem_req_ready = 1'b0, mem_fill_valid = 1'b0;
    logic [255:0] mem_fill_data = '0;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [31:0] exp_line = '0;
    int          delay_sel = 0;

    typedef struct {
        bit          hit;
        logic [31:0] data;
        int          cyc;
        string       rq;
    } exp_t;
    exp_t sb[$];

    logic [17:0] m_tag [2][512];
    bit          m_val [2][512];
    bit          m_mru [512];
    logic [31:0] m_dat [2][512][8];

    c2w_cache i_c2w_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_fill_valid(mem_fill_valid),
        .mem_fill_data(mem_fill_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Reference model updated at the acceptance edge; pushes the expected response.
    task automatic issue(bit wr, logic [31:0] a, logic [31:0] wd, string rq);
        int   s, ws;
        bit   h, w;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        s  = int'(a[13:5]);
        ws = int'(a[4:2]);
        h  = 1'b0; w = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (m_val[k][s] && m_tag[k][s] == a[31:14]) begin h = 1'b1; w = k[0]; end
        end
        if (!h) begin
            w = ~m_mru[s];
            m_val[w][s] = 1'b1;
            m_tag[w][s] = a[31:14];
            for (int k = 0; k < 8; k++) m_dat[w][s][k] = mem_word({a[31:5], 5'd0} + 32'(k * 4));
            exp_line = {a[31:5], 5'd0};
        end
        m_mru[s] = w;
        if (wr) m_dat[w][s][ws] = wd;
        e.hit = h; e.data = m_dat[w][s][ws]; e.cyc = cyc; e.rq = rq;
        sb.push_back(e);
    endtask

    // Monitor: pops the scoreboard on every response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected response", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_hit == e.hit, e.rq, "hit flag", 32'(rsp_hit), 32'(e.hit));
                check(rsp_rdata == e.data, e.rq, "read word", rsp_rdata, e.data);
                if (e.hit) check(cyc == e.cyc, "R2", "hit latency cycle", 32'(cyc), 32'(e.cyc));
            end
        end
    end

    // Memory responder with varying handshake delay.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                check(mem_req_addr == exp_line, "R3", "fill address", mem_req_addr, exp_line);
                repeat (delay_sel % 3) begin
                    @(negedge clk);
                    check(mem_req_valid && mem_req_addr == exp_line, "R3", "request held",
                          mem_req_addr, exp_line);
                end
                delay_sel++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (3) @(negedge clk);
                for (int k = 0; k < 8; k++) mem_fill_data[k*32 +: 32] = mem_word(exp_line + 32'(k * 4));
                mem_fill_valid = 1'b1;
                check(!req_ready, "R7", "ready low during fill", 32'(req_ready), 32'h0);
                @(negedge clk);
                mem_fill_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    localparam logic [31:0] A = 32'h0001_4060; // set 3, tag 5
    localparam logic [31:0] B = 32'h0001_8060; // set 3, tag 6
    localparam logic [31:0] C = 32'h0001_C060; // set 3, tag 7
    localparam logic [31:0] D = 32'h0002_0A44; // set 82, tag 8

    initial begin
        for (int s = 0; s < 512; s++) begin
            m_mru[s] = 1'b0;
            for (int k = 0; k < 2; k++) m_val[k][s] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R8: idle outputs during reset
        check(req_ready == 1'b1, "R8", "req_ready in reset", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0, "R8", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        check(mem_req_valid == 1'b0, "R8", "mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
        rst = 1'b0;

        issue(0, A, 0, "R8");          // cold miss, fills way 1
        issue(0, A + 32'h8, 0, "R2");  // hit, word 2
        issue(0, A | 32'h1F, 0, "R1"); // offset bits only: same line, word 7
        issue(0, B, 0, "R5");          // miss, fills way 0
        issue(0, A, 0, "R6");          // hit, A becomes MRU
        issue(0, C, 0, "R6");          // evicts B
        issue(0, A + 32'h4, 0, "R6");  // A still resident
        issue(0, B, 0, "R6");          // B misses again, evicts C
        issue(0, C, 0, "R5");          // C misses, evicts A
        issue(0, B + 32'h4, 0, "R2");
        issue(1, B + 32'h4, 32'hDEAD_BEEF, "R9");
        issue(0, B + 32'h4, 0, "R9");
        issue(0, B + 32'h8, 0, "R9");
        issue(1, D, 32'h1234_5678, "R10");
        issue(0, D, 0, "R10");
        issue(0, D + 32'h4, 0, "R10");
        // sweep: sequential lines across sets, each touched twice
        for (int i = 0; i < 12; i++) begin
            issue(0, 32'h0040_0000 + 32'(i * 32) + 32'(4 * (i % 8)), 0, "R4");
            issue(0, 32'h0040_0000 + 32'(i * 32), 0, "R1");
        end
        // same index, tags differing only in high bits (R1)
        issue(0, 32'h8000_4060, 0, "R1");
        issue(0, 32'h8000_4064, 0, "R1");

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R2", "all responses delivered", 32'(sb.size()), 32'h0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule